// File: doc/BRIEF.md
# Seven-Operand Carry-Save Tree Adder

This block adds seven unsigned operands of K bits each in a single combinational pass. Layers of 3:2 compressor rows shrink the operand set until only two vectors remain. Each row is a bank of independent one-bit full or half adders with no carry chain. A ripple-carry adder then joins those two vectors. The result is wide enough for the largest possible total, so it never wraps.

A compile-time parameter selects the reduction schedule. The early schedule compresses as many vectors as it can in every layer. The lean schedule compresses only down to the largest count that the remaining layers can still finish, which keeps cells out of the early layers. Both schedules reach two vectors in four layers. Every compressor row is sized from the tracked width of its inputs, so a column that holds only one live bit becomes a plain wire and a column with two live bits becomes a half adder.

Top module: `cst_tree_adder7`

## Requirements
- R1: `sum_o` is K+3 bits wide (9 bits at K=6) and equals the exact sum of the seven operands for every input. Operand i sits in `ops_i` bits i·K up to i·K+K−1.
- R2: When every operand is all ones, `sum_o` equals 7·(2^K − 1), which is 441 at K=6. This value lies inside the K+3-bit range, and no carry leaves the final adder.
- R3: When every operand is zero, `sum_o` is zero.
- R4: In every compressor row, the three inputs add up to the sum vector plus the carry vector. The carry of column i is placed in column i+1, and no carry leaves the top column.
- R5: Every reduction layer keeps the total: the sum of its output vectors equals the sum of its input vectors.
- R6: After four layers exactly two nonzero vectors remain. The early schedule holds 7, 5, 4, 3 and 2 vectors from layer to layer. The lean schedule holds 7, 6, 4, 3 and 2.
- R7: Both schedule settings give the same `sum_o` for the same operands.
- R8: The final ripple-carry adder's sum and carry-out equal the exact sum of its two input vectors.
- R9: When only one operand is nonzero, `sum_o` equals that operand's value, whichever of the seven positions it occupies.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ops_i | input | 7·K | Seven packed unsigned operands, operand i in bits [i·K +: K] |
| sum_o | output | K+3 | Full-precision total of the seven operands |

## Verification
The operands 1 through 7 and a set of mixed values close to the maximum show that carries move correctly across both the compressor layers and the final adder. All-ones inputs reach the top of the result range, so a dropped carry in the top column would show there. All-zeros inputs show that no stray constant enters the sum. A single nonzero operand walked through all seven slots exposes any slot that is routed wrongly, skipped in a layer or given a truncated width. Random operands are applied to both schedule settings at once, so any difference between the two trees shows up as a mismatch.

// File: rtl/cst_pkg.sv
package cst_pkg;

   // Number of operands summed by the tree.
   localparam int N_OPS = 7;
   // Bit width of one packed width-table field.
   localparam int WFLD  = 8;

   typedef enum logic {
      SCHED_EARLY = 1'b0,
      SCHED_LEAN  = 1'b1
   } sched_e;

   // Result width: enough bits to hold N_OPS * (2^k - 1).
   function automatic int sum_bits(input int k);
      return k + $clog2(N_OPS);
   endfunction

   // Largest count in the 2,3,4,6,9,... ladder that is below n.
   function automatic int lean_target(input int n);
      int d;
      d = 2;
      while (((d * 3) / 2) < n) d = (d * 3) / 2;
      return d;
   endfunction

   // Number of 3:2 rows placed in a layer that sees n vectors.
   function automatic int groups_at(input int n, input sched_e s);
      if (n <= 2) return 0;
      if (s == SCHED_LEAN) return n - lean_target(n);
      return n / 3;
   endfunction

   // Vector count entering layer st.
   function automatic int count_at(input int st, input sched_e s);
      int n;
      n = N_OPS;
      for (int i = 0; i < st; i++) n -= groups_at(n, s);
      return n;
   endfunction

   // Number of layers the schedule needs to reach two vectors.
   function automatic int layer_total(input sched_e s);
      int n;
      int c;
      n = N_OPS;
      c = 0;
      while (n > 2) begin
         n -= groups_at(n, s);
         c++;
      end
      return c;
   endfunction

   // Smallest possible tree height for n0 operands.
   function automatic int min_height(input int n0);
      int n;
      int h;
      n = n0;
      h = 0;
      while (n > 2) begin
         n = (2 * n + 2) / 3;
         h++;
      end
      return h;
   endfunction

   // Live bit widths of every vector slot entering layer st, packed.
   function automatic logic [N_OPS*WFLD-1:0] layer_widths(input int st, input int k,
                                                          input sched_e s);
      int w  [N_OPS];
      int nw [N_OPS];
      int n;
      int g;
      int hi;
      int mid;
      int lo;
      int t;
      int top;
      logic [N_OPS*WFLD-1:0] pk;
      top = sum_bits(k);
      for (int i = 0; i < N_OPS; i++) w[i] = k;
      n = N_OPS;
      for (int l = 0; l < st; l++) begin
         g = groups_at(n, s);
         for (int i = 0; i < N_OPS; i++) nw[i] = 0;
         for (int j = 0; j < g; j++) begin
            hi  = w[3*j];
            mid = w[3*j+1];
            lo  = w[3*j+2];
            if (mid > hi) begin t = hi; hi = mid; mid = t; end
            if (lo > hi)  begin t = hi; hi = lo;  lo  = t; end
            if (lo > mid) begin t = mid; mid = lo; lo = t; end
            nw[2*j]   = hi;
            nw[2*j+1] = (mid == 0) ? 0 : (((mid + 1) > top) ? top : (mid + 1));
         end
         for (int r = 3 * g; r < n; r++) nw[2*g + r - 3*g] = w[r];
         for (int i = 0; i < N_OPS; i++) w[i] = nw[i];
         n -= g;
      end
      pk = '0;
      for (int i = 0; i < N_OPS; i++) pk[i*WFLD +: WFLD] = WFLD'(w[i]);
      return pk;
   endfunction

   function automatic int width_of(input int st, input int idx, input int k, input sched_e s);
      logic [N_OPS*WFLD-1:0] v;
      v = layer_widths(st, k, s);
      return int'(v[idx*WFLD +: WFLD]);
   endfunction

endpackage

// File: rtl/cst_csa_row.sv
module cst_csa_row #(
   parameter int W  = 9,
   parameter int WX = 6,
   parameter int WY = 6,
   parameter int WZ = 6
) (
   input  logic [W-1:0] x_i,
   input  logic [W-1:0] y_i,
   input  logic [W-1:0] z_i,
   output logic [W-1:0] sum_o,
   output logic [W-1:0] cry_o
);

   // col_cry[i+1] is the carry produced by column i.
   logic [W:0] col_cry;

   if (WX > W || WY > W || WZ > W) begin : g_bad_width
      $error("cst_csa_row: input width exceeds row width");
   end

   assign col_cry[0] = 1'b0;

   for (genvar i = 0; i < W; i++) begin : g_col
      localparam int NIN = int'(i < WX) + int'(i < WY) + int'(i < WZ);
      if (NIN == 3) begin : g_fa
         assign sum_o[i]     = x_i[i] ^ y_i[i] ^ z_i[i];
         assign col_cry[i+1] = (x_i[i] & y_i[i]) | (x_i[i] & z_i[i]) | (y_i[i] & z_i[i]);
      end else if (NIN == 2) begin : g_ha
         logic p;
         logic q;
         assign p            = (i < WX) ? x_i[i] : y_i[i];
         assign q            = (i < WZ) ? z_i[i] : y_i[i];
         assign sum_o[i]     = p ^ q;
         assign col_cry[i+1] = p & q;
      end else if (NIN == 1) begin : g_wire
         assign sum_o[i]     = (i < WX) ? x_i[i] : ((i < WY) ? y_i[i] : z_i[i]);
         assign col_cry[i+1] = 1'b0;
      end else begin : g_empty
         assign sum_o[i]     = 1'b0;
         assign col_cry[i+1] = 1'b0;
      end
   end

   assign cry_o = col_cry[W-1:0];

   always_comb begin
      if (!$isunknown({x_i, y_i, z_i})) begin
         AST_CSA_BALANCE: assert (({2'b00, x_i} + {2'b00, y_i} + {2'b00, z_i})
                                  == ({2'b00, sum_o} + {2'b00, cry_o}))
            else $error("compressor row lost value"); // R4
         AST_CSA_TOP_CARRY: assert (col_cry[W] == 1'b0)
            else $error("carry left the top column"); // R4
      end
   end

endmodule

// File: rtl/cst_reduce_layer.sv
module cst_reduce_layer
   import cst_pkg::*;
#(
   parameter int     K     = 6,
   parameter int     W     = 9,
   parameter sched_e SCHED = SCHED_EARLY,
   parameter int     STG   = 0
) (
   input  logic [N_OPS-1:0][W-1:0] vin_i,
   output logic [N_OPS-1:0][W-1:0] vout_o
);

   localparam int N_IN  = count_at(STG, SCHED);
   localparam int G     = groups_at(N_IN, SCHED);
   localparam int N_OUT = N_IN - G;
   localparam int SW    = W + 3;

   if (G < 1) begin : g_bad_layer
      $error("cst_reduce_layer: layer has no compressor rows");
   end

   for (genvar j = 0; j < G; j++) begin : g_row
      cst_csa_row #(
         .W (W),
         .WX(width_of(STG, 3*j,     K, SCHED)),
         .WY(width_of(STG, 3*j + 1, K, SCHED)),
         .WZ(width_of(STG, 3*j + 2, K, SCHED))
      ) u_row (
         .x_i  (vin_i[3*j]),
         .y_i  (vin_i[3*j + 1]),
         .z_i  (vin_i[3*j + 2]),
         .sum_o(vout_o[2*j]),
         .cry_o(vout_o[2*j + 1])
      );
   end

   for (genvar r = 3 * G; r < N_IN; r++) begin : g_pass
      assign vout_o[2*G + r - 3*G] = vin_i[r];
   end

   for (genvar o = N_OUT; o < N_OPS; o++) begin : g_zero
      assign vout_o[o] = '0;
   end

   logic [SW-1:0] tot_in;
   logic [SW-1:0] tot_out;

   always_comb begin
      tot_in  = '0;
      tot_out = '0;
      for (int i = 0; i < N_OPS; i++) begin
         tot_in  = tot_in  + SW'(vin_i[i]);
         tot_out = tot_out + SW'(vout_o[i]);
      end
      if (!$isunknown(vin_i)) begin
         AST_LAYER_SUM: assert (tot_in == tot_out)
            else $error("layer %0d changed the total", STG); // R5
      end
   end

endmodule

// File: rtl/cst_ripple_cpa.sv
module cst_ripple_cpa #(
   parameter int W = 9
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   output logic [W-1:0] sum_o,
   output logic         cout_o
);

   logic [W:0] chain;

   assign chain[0] = 1'b0;

   for (genvar i = 0; i < W; i++) begin : g_bit
      assign sum_o[i]   = a_i[i] ^ b_i[i] ^ chain[i];
      assign chain[i+1] = (a_i[i] & b_i[i]) | (chain[i] & (a_i[i] ^ b_i[i]));
   end

   assign cout_o = chain[W];

   always_comb begin
      if (!$isunknown({a_i, b_i})) begin
         AST_CPA_EXACT: assert ({cout_o, sum_o} == ({1'b0, a_i} + {1'b0, b_i}))
            else $error("ripple adder result differs"); // R8
      end
   end

endmodule

// File: rtl/cst_tree_adder7.sv
module cst_tree_adder7
   import cst_pkg::*;
#(
   parameter int     K     = 6,
   parameter sched_e SCHED = SCHED_EARLY,
   localparam int    W     = K + $clog2(N_OPS)
) (
   input  logic [N_OPS*K-1:0] ops_i,
   output logic [W-1:0]       sum_o
);

   localparam int NLAY = layer_total(SCHED);

   if (K < 1) begin : g_bad_k
      $error("cst_tree_adder7: K must be at least 1");
   end
   if (W != sum_bits(K)) begin : g_bad_w
      $error("cst_tree_adder7: result width mismatch");
   end
   if (NLAY != min_height(N_OPS)) begin : g_bad_height
      $error("cst_tree_adder7: schedule is taller than the minimum tree");
   end

   logic [N_OPS-1:0][W-1:0] lvl [NLAY+1];
   logic                    cpa_cout;

   for (genvar i = 0; i < N_OPS; i++) begin : g_load
      assign lvl[0][i] = {{(W-K){1'b0}}, ops_i[i*K +: K]};
   end

   for (genvar st = 0; st < NLAY; st++) begin : g_layer
      cst_reduce_layer #(
         .K    (K),
         .W    (W),
         .SCHED(SCHED),
         .STG  (st)
      ) u_layer (
         .vin_i (lvl[st]),
         .vout_o(lvl[st+1])
      );
   end

   cst_ripple_cpa #(
      .W(W)
   ) u_cpa (
      .a_i   (lvl[NLAY][0]),
      .b_i   (lvl[NLAY][1]),
      .sum_o (sum_o),
      .cout_o(cpa_cout)
   );

   localparam logic [W-1:0] SUM_MAX = W'(N_OPS) * ((W'(1) << K) - W'(1));

   always_comb begin
      if (!$isunknown(ops_i)) begin
         AST_NO_OVERFLOW: assert (cpa_cout == 1'b0)
            else $error("final adder carried out"); // R1
         AST_SUM_BOUND: assert (sum_o <= SUM_MAX)
            else $error("sum above the largest possible total"); // R2
         for (int i = 2; i < N_OPS; i++) begin
            AST_TWO_LEFT: assert (lvl[NLAY][i] == '0)
               else $error("more than two vectors reach the final adder"); // R6
         end
      end
   end

endmodule

// File: tb/test_cst_tree_adder7.sv
module test_cst_tree_adder7;
   import cst_pkg::*;

   localparam int K          = 6;
   localparam int W          = K + 3;
   localparam int CLK_PERIOD = 10;
   localparam int NVEC       = 8;
   localparam int NRAND      = 300;

   // Seven operands followed by the expected total.
   localparam int VEC_TBL [NVEC][N_OPS+1] = '{
      '{ 1,  2,  3,  4,  5,  6,  7,  28},
      '{63, 63, 63, 63, 63, 63, 63, 441},
      '{ 0,  0,  0,  0,  0,  0,  0,   0},
      '{63,  0,  0,  0,  0,  0,  0,  63},
      '{ 0,  0,  0,  0,  0,  0, 63,  63},
      '{32, 32, 32, 32, 32, 32, 32, 224},
      '{10, 20, 30, 40, 50, 60,  5, 215},
      '{63, 62, 61, 60, 59, 58, 57, 420}
   };

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic [N_OPS*K-1:0] ops = '0;
   logic [W-1:0]       sum_early;
   logic [W-1:0]       sum_lean;
   int                 n_chk = 0;
   int                 n_fail = 0;
   bit                 done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cst_tree_adder7 #(.K(K), .SCHED(SCHED_EARLY)) i_cst_tree_adder7 (
      .ops_i(ops),
      .sum_o(sum_early)
   );

   cst_tree_adder7 #(.K(K), .SCHED(SCHED_LEAN)) i_cst_tree_adder7_lean (
      .ops_i(ops),
      .sum_o(sum_lean)
   );

   task automatic chk(input string tag, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic run_vec(input int v [N_OPS], input int exp, input string tag);
      @(negedge clk);
      for (int i = 0; i < N_OPS; i++) ops[i*K +: K] = K'(v[i]);
      #(CLK_PERIOD/4);
      chk(tag, "early schedule", int'(sum_early), exp);
      chk(tag, "lean schedule", int'(sum_lean), exp);
      chk("R7", "schedules agree", int'(sum_lean), int'(sum_early));
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL R1 watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      int v [N_OPS];
      int exp;

      // Reset state: zero operands give a zero total (R3).
      repeat (2) @(posedge clk);
      #(CLK_PERIOD/4);
      chk("R3", "reset state early", int'(sum_early), 0);
      chk("R3", "reset state lean", int'(sum_lean), 0);
      rst_n = 1'b1;

      // Table walk: exact totals, rows and layers preserve value (R1 R4 R5 R6 R8).
      for (int r = 0; r < NVEC; r++) begin
         for (int i = 0; i < N_OPS; i++) v[i] = VEC_TBL[r][i];
         run_vec(v, VEC_TBL[r][N_OPS], "R1 R4 R5 R6 R8");
      end

      // All ones: top of range, no overflow (R2).
      for (int i = 0; i < N_OPS; i++) v[i] = (1 << K) - 1;
      run_vec(v, N_OPS * ((1 << K) - 1), "R2");

      // All zeros (R3).
      for (int i = 0; i < N_OPS; i++) v[i] = 0;
      run_vec(v, 0, "R3");

      // One nonzero operand in each slot (R9).
      for (int p = 0; p < N_OPS; p++) begin
         for (int i = 0; i < N_OPS; i++) v[i] = 0;
         v[p] = (p + 1) * 9;
         run_vec(v, (p + 1) * 9, "R9");
         v[p] = (1 << K) - 1;
         run_vec(v, (1 << K) - 1, "R9");
      end

      // Random operands against a behavioural total (R1 R7).
      for (int n = 0; n < NRAND; n++) begin
         exp = 0;
         for (int i = 0; i < N_OPS; i++) begin
            v[i] = int'($urandom_range((1 << K) - 1, 0));
            exp += v[i];
         end
         run_vec(v, exp, "R1 R7");
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule